// File: doc/BRIEF.md
# Value Belt with Predicated Select and Reorder

This block holds a short queue of tagged result values, the belt, in which every new result enters at the front (position 0) and every older value moves one place toward the back. The value that would move past the last position is discarded. Each position carries a valid flag beside its data word, so a consumer can tell a real value from an empty or discarded one. By default the belt has 8 positions of 32 bits, and up to 2 functional-unit results can enter it in one cycle.

Besides plain drops, the block offers two operations that rename existing values and compute nothing new. Select reads three positions: a predicate and two candidates. It places the chosen candidate at the front in the same update as the ordinary drops of that cycle, so it adds no pipeline stage. Reorder rebuilds the whole belt in one cycle from a list of source positions. A block of code uses it to hand values to the code that follows a branch in the positions that code expects. A single registered read port returns the data and valid state of any position.

Top module: `val_belt`

## Requirements
- R1: While `rst` is high at a clock edge, every position becomes invalid with data zero, and `rd_data` and `rd_err` are cleared.
- R2: At each clock edge the read port registers the position addressed by `rd_idx`, as it stands just before that edge. It then shows that data on `rd_data` and its missing valid flag on `rd_err`. Position 0 is the newest.
- R3: One drop moves every value one position toward the back, puts the new value valid at position 0, and loses the value at position NPOS-1.
- R4: Drops offered in one cycle enter in ascending slot order, so the highest valid slot ends nearest the front. Slots with `drop_vld` low take no place, and the belt shifts by the number of valid slots.
- R5: When `pick_en` is high, the predicate is true if bit 0 of the value at `pick_pred` is 1. True selects the value at `pick_a`, false selects the value at `pick_b`. All three indices refer to the belt as it stood before the edge. The result enters as the newest value of the same update, ahead of that cycle's drops.
- R6: If the predicate position or the selected candidate position is invalid, the entry dropped by a select is invalid.
- R7: When `conf_en` is high, new position i takes both data and valid flag from the old position named in `conf_map[i*CW +: CW]`, where CW = log2(NPOS)+1. This happens in one cycle, and one source may feed several positions.
- R8: A reorder field whose value is NPOS or more makes that position invalid.
- R9: While `conf_en` is high, the drops and any select offered in the same cycle are ignored.
- R10: A cycle with no drop, no select and no reorder leaves the belt unchanged.
- R11: Reading an invalid position gives `rd_data` zero and `rd_err` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the belt |
| drop_vld | input | NDROP | Per-slot drop request |
| drop_data | input | NDROP*W | Per-slot drop values, slot j at bits [j*W +: W] |
| pick_en | input | 1 | Request a predicated select |
| pick_pred | input | log2(NPOS) | Position holding the predicate |
| pick_a | input | log2(NPOS) | Candidate taken when the predicate is true |
| pick_b | input | log2(NPOS) | Candidate taken when the predicate is false |
| conf_en | input | 1 | Request a reorder of the whole belt |
| conf_map | input | NPOS*CW | Source position for each destination position |
| rd_idx | input | log2(NPOS) | Position to read |
| rd_data | output | W | Registered read data, zero if invalid |
| rd_err | output | 1 | Registered flag for a read of an invalid position |

## Verification
A wrong shift count or a wrong slot order puts every later value in the wrong place. It shows on the read port one cycle after the next read of any affected position, and it stays visible until the values fall off the back. A select that takes the wrong candidate or the wrong validity appears at position 0 on the first read after the edge. A reorder or priority error changes the whole belt in a single edge, so it is reported by the read sweep that follows that operation.

// File: rtl/belt_pkg.sv
package belt_pkg;

  typedef enum logic [1:0] {
    BOP_IDLE    = 2'd0,
    BOP_PUSH    = 2'd1,
    BOP_CONFORM = 2'd2
  } belt_op_e;

endpackage

// File: rtl/belt_pick.sv
module belt_pick #(
  parameter int NPOS = 8,
  parameter int W    = 32,
  parameter int IW   = 3
) (
  input  logic [W-1:0]    cur_data [NPOS],
  input  logic [NPOS-1:0] cur_vld,
  input  logic [IW-1:0]   pred_idx,
  input  logic [IW-1:0]   a_idx,
  input  logic [IW-1:0]   b_idx,
  output logic            res_vld,
  output logic [W-1:0]    res_data
);

  logic          pred_true;
  logic [IW-1:0] sel_idx;

  always_comb begin
    pred_true = cur_data[pred_idx][0];
    sel_idx   = pred_true ? a_idx : b_idx;
    res_vld   = cur_vld[pred_idx] && cur_vld[sel_idx];
    res_data  = res_vld ? cur_data[sel_idx] : '0;
  end

endmodule

// File: rtl/belt_shift.sv
module belt_shift #(
  parameter int NPOS = 8,
  parameter int W    = 32,
  parameter int NIN  = 3
) (
  input  logic [W-1:0]    cur_data [NPOS],
  input  logic [NPOS-1:0] cur_vld,
  input  logic [NIN-1:0]  in_use,
  input  logic [NIN-1:0]  in_vld,
  input  logic [W-1:0]    in_data [NIN],
  output logic [W-1:0]    nxt_data [NPOS],
  output logic [NPOS-1:0] nxt_vld
);

  // newest-first compacted list of incoming entries
  logic [W-1:0]   q_data [NIN];
  logic [NIN-1:0] q_vld;
  int             n_new;

  always_comb begin
    n_new = 0;
    for (int k = 0; k < NIN; k++) begin
      q_data[k] = '0;
      q_vld[k]  = 1'b0;
    end
    for (int j = NIN - 1; j >= 0; j--) begin
      if (in_use[j]) begin
        for (int k = 0; k < NIN; k++) begin
          if (k == n_new) begin
            q_data[k] = in_data[j];
            q_vld[k]  = in_vld[j];
          end
        end
        n_new = n_new + 1;
      end
    end
  end

  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    always_comb begin
      nxt_data[i] = '0;
      nxt_vld[i]  = 1'b0;
      for (int s = 0; s < NPOS; s++) begin
        if (s + n_new == i) begin
          nxt_data[i] = cur_data[s];
          nxt_vld[i]  = cur_vld[s];
        end
      end
      for (int k = 0; k < NIN; k++) begin
        if (k == i && k < n_new) begin
          nxt_data[i] = q_data[k];
          nxt_vld[i]  = q_vld[k];
        end
      end
    end
  end

endmodule

// File: rtl/belt_conform.sv
module belt_conform #(
  parameter int NPOS = 8,
  parameter int W    = 32,
  parameter int CW   = 4
) (
  input  logic [W-1:0]     cur_data [NPOS],
  input  logic [NPOS-1:0]  cur_vld,
  input  logic [NPOS*CW-1:0] map,
  output logic [W-1:0]     nxt_data [NPOS],
  output logic [NPOS-1:0]  nxt_vld
);

  for (genvar i = 0; i < NPOS; i++) begin : g_dst
    logic [CW-1:0] src;
    assign src = map[i*CW +: CW];

    always_comb begin
      nxt_data[i] = '0;
      nxt_vld[i]  = 1'b0;
      for (int s = 0; s < NPOS; s++) begin
        if (src == CW'(s)) begin
          nxt_data[i] = cur_data[s];
          nxt_vld[i]  = cur_vld[s];
        end
      end
    end
  end

endmodule

// File: rtl/belt_rdport.sv
module belt_rdport #(
  parameter int NPOS = 8,
  parameter int W    = 32,
  parameter int IW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    cur_data [NPOS],
  input  logic [NPOS-1:0] cur_vld,
  input  logic [IW-1:0]   rd_idx,
  output logic [W-1:0]    rd_data,
  output logic            rd_err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rd_data <= cur_vld[rd_idx] ? cur_data[rd_idx] : '0;
      rd_err  <= !cur_vld[rd_idx];
    end
  end

  p_err_zero_r11: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_data == '0));

endmodule

// File: rtl/val_belt.sv
module val_belt #(
  parameter int NPOS  = 8,
  parameter int W     = 32,
  parameter int NDROP = 2,
  localparam int IW   = $clog2(NPOS),
  localparam int CW   = IW + 1,
  localparam int NIN  = NDROP + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NDROP-1:0]     drop_vld,
  input  logic [NDROP*W-1:0]   drop_data,
  input  logic                 pick_en,
  input  logic [IW-1:0]        pick_pred,
  input  logic [IW-1:0]        pick_a,
  input  logic [IW-1:0]        pick_b,
  input  logic                 conf_en,
  input  logic [NPOS*CW-1:0]   conf_map,
  input  logic [IW-1:0]        rd_idx,
  output logic [W-1:0]         rd_data,
  output logic                 rd_err
);
  import belt_pkg::*;

  logic [W-1:0]    ent_d [NPOS];
  logic [NPOS-1:0] ent_v;

  logic [W-1:0]    pk_d;
  logic            pk_v;

  logic [NIN-1:0]  in_use;
  logic [NIN-1:0]  in_vld;
  logic [W-1:0]    in_data [NIN];

  logic [W-1:0]    sh_d [NPOS];
  logic [NPOS-1:0] sh_v;
  logic [W-1:0]    cf_d [NPOS];
  logic [NPOS-1:0] cf_v;

  belt_op_e op;

  // drop slots first, select result in the highest (newest) slot
  for (genvar j = 0; j < NDROP; j++) begin : g_slot
    assign in_use[j]  = drop_vld[j];
    assign in_vld[j]  = 1'b1;
    assign in_data[j] = drop_data[j*W +: W];
  end
  assign in_use[NDROP]  = pick_en;
  assign in_vld[NDROP]  = pk_v;
  assign in_data[NDROP] = pk_d;

  belt_pick #(.NPOS(NPOS), .W(W), .IW(IW)) u_pick (
    .cur_data (ent_d),
    .cur_vld  (ent_v),
    .pred_idx (pick_pred),
    .a_idx    (pick_a),
    .b_idx    (pick_b),
    .res_vld  (pk_v),
    .res_data (pk_d)
  );

  belt_shift #(.NPOS(NPOS), .W(W), .NIN(NIN)) u_shift (
    .cur_data (ent_d),
    .cur_vld  (ent_v),
    .in_use   (in_use),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .nxt_data (sh_d),
    .nxt_vld  (sh_v)
  );

  belt_conform #(.NPOS(NPOS), .W(W), .CW(CW)) u_conform (
    .cur_data (ent_d),
    .cur_vld  (ent_v),
    .map      (conf_map),
    .nxt_data (cf_d),
    .nxt_vld  (cf_v)
  );

  belt_rdport #(.NPOS(NPOS), .W(W), .IW(IW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .cur_data (ent_d),
    .cur_vld  (ent_v),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rd_err   (rd_err)
  );

  always_comb begin
    if (conf_en)                   op = BOP_CONFORM;
    else if (|in_use)              op = BOP_PUSH;
    else                           op = BOP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPOS; i++) ent_d[i] <= '0;
      ent_v <= '0;
    end else begin
      case (op)
        BOP_PUSH: begin
          ent_d <= sh_d;
          ent_v <= sh_v;
        end
        BOP_CONFORM: begin
          ent_d <= cf_d;
          ent_v <= cf_v;
        end
        default: ;
      endcase
    end
  end

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!conf_en && !pick_en && drop_vld == '0) |=> ($stable(ent_v) && $stable(ent_d[0])));

  p_pick_front_r5: assert property (@(posedge clk) disable iff (rst)
    (pick_en && !conf_en) |=> (ent_d[0] == $past(pk_d) && ent_v[0] == $past(pk_v)));

  p_one_drop_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (!conf_en && !pick_en && $countones(drop_vld) == 1)
      |=> (ent_d[1] == $past(ent_d[0]) && ent_v[1] == $past(ent_v[0]) && ent_v[0]));

  p_conf_range_r8: assert property (@(posedge clk) disable iff (rst)
    (conf_en && conf_map[CW-1:0] >= CW'(NPOS)) |=> !ent_v[0]);

  p_conf_prio_r9: assert property (@(posedge clk) disable iff (rst)
    conf_en |=> (ent_v == $past(cf_v)));

endmodule

// File: tb/val_belt_bench.sv
module val_belt_bench;
  localparam int NPOS = 8;
  localparam int W = 32;
  localparam int NDROP = 2;
  localparam int IW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NDROP-1:0] drop_vld = '0;
  logic [NDROP*W-1:0] drop_data = '0;
  logic pick_en = 1'b0;
  logic [IW-1:0] pick_pred = '0, pick_a = '0, pick_b = '0;
  logic conf_en = 1'b0;
  logic [NPOS*CW-1:0] conf_map = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [W-1:0] rd_data;
  logic rd_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_d [NPOS];
  logic m_v [NPOS];

  always #10 clk = ~clk;

  val_belt #(.NPOS(NPOS), .W(W), .NDROP(NDROP)) u_val_belt (
    .clk(clk), .rst(rst), .drop_vld(drop_vld), .drop_data(drop_data),
    .pick_en(pick_en), .pick_pred(pick_pred), .pick_a(pick_a), .pick_b(pick_b),
    .conf_en(conf_en), .conf_map(conf_map), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic model_clear();
    for (int i = 0; i < NPOS; i++) begin m_d[i] = '0; m_v[i] = 1'b0; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // model push of one entry at the front
  task automatic m_push(input logic [W-1:0] d, input logic v);
    for (int i = NPOS - 1; i > 0; i--) begin m_d[i] = m_d[i-1]; m_v[i] = m_v[i-1]; end
    m_d[0] = v ? d : '0;
    m_v[0] = v;
  endtask

  task automatic do_op(input logic [1:0] dv, input logic [W-1:0] d0, input logic [W-1:0] d1,
                       input logic pe, input int pp, input int pa, input int pb,
                       input logic ce, input logic [NPOS*CW-1:0] cmap);
    logic [W-1:0] od [NPOS];
    logic ov [NPOS];
    logic pv;
    logic [W-1:0] pd;
    int sel;
    for (int i = 0; i < NPOS; i++) begin od[i] = m_d[i]; ov[i] = m_v[i]; end
    if (ce) begin
      for (int i = 0; i < NPOS; i++) begin
        int f;
        f = int'(cmap[i*CW +: CW]);
        if (f < NPOS) begin m_d[i] = od[f]; m_v[i] = ov[f]; end
        else begin m_d[i] = '0; m_v[i] = 1'b0; end
      end
    end else begin
      sel = od[pp][0] ? pa : pb;
      pv = ov[pp] && ov[sel];
      pd = pv ? od[sel] : '0;
      if (dv[0]) m_push(d0, 1'b1);
      if (dv[1]) m_push(d1, 1'b1);
      if (pe) m_push(pd, pv);
    end
    @(negedge clk);
    drop_vld = dv; drop_data = {d1, d0};
    pick_en = pe; pick_pred = IW'(pp); pick_a = IW'(pa); pick_b = IW'(pb);
    conf_en = ce; conf_map = cmap;
    @(negedge clk);
    drop_vld = '0; pick_en = 1'b0; conf_en = 1'b0;
  endtask

  task automatic drop1(input logic [W-1:0] d);
    do_op(2'b01, d, '0, 1'b0, 0, 0, 0, 1'b0, '0);
  endtask

  task automatic check_belt(input string req);
    for (int i = 0; i < NPOS; i++) begin
      @(negedge clk); rd_idx = IW'(i);
      @(negedge clk);
      n_run++;
      if (rd_data !== (m_v[i] ? m_d[i] : '0) || rd_err !== !m_v[i]) begin
        n_fail++;
        $display("FAIL %s pos %0d: data %h err %b, expected data %h err %b",
                 req, i, rd_data, rd_err, (m_v[i] ? m_d[i] : 32'h0), !m_v[i]);
      end
    end
  endtask

  task automatic t_reset();
    n_run++;
    if (rd_data !== '0 || rd_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 read port in reset: data %h err %b, expected 0 0", rd_data, rd_err);
    end
    do_reset();
    check_belt("R1/R11 empty after reset");
  endtask

  task automatic t_single_drop();
    for (int k = 0; k < 3; k++) drop1(32'h100 + k);
    check_belt("R2/R3 three drops");
    for (int k = 3; k < 11; k++) drop1(32'h100 + k);
    check_belt("R3 overflow off the back");
  endtask

  task automatic t_multi_drop();
    do_op(2'b11, 32'hA0A0, 32'hB1B1, 1'b0, 0, 0, 0, 1'b0, '0);
    check_belt("R4 two slots same cycle");
    do_op(2'b10, 32'hDEAD, 32'hC2C2, 1'b0, 0, 0, 0, 1'b0, '0);
    check_belt("R4 only slot 1 valid");
  endtask

  task automatic t_pick();
    do_reset();
    drop1(32'h11);  // pos3 later: candidate b
    drop1(32'h22);  // candidate a
    drop1(32'h2);   // predicate false
    drop1(32'h3);   // predicate true
    // belt: 0:3 1:2 2:22 3:11
    do_op(2'b00, '0, '0, 1'b1, 0, 2, 3, 1'b0, '0);
    check_belt("R5 predicate true selects first");
    // belt: 0:22 1:3 2:2 3:22 4:11
    do_op(2'b01, 32'h77, '0, 1'b1, 2, 0, 4, 1'b0, '0);
    check_belt("R5 predicate false with same-cycle drop");
  endtask

  task automatic t_pick_invalid();
    do_reset();
    drop1(32'h5);
    drop1(32'h1);
    // belt: 0:1 1:5
    do_op(2'b00, '0, '0, 1'b1, 6, 0, 1, 1'b0, '0);
    check_belt("R6 invalid predicate");
    // belt: 0:inv 1:1 2:5 ; predicate pos1 true -> pick_a pos7 invalid
    do_op(2'b00, '0, '0, 1'b1, 1, 7, 2, 1'b0, '0);
    check_belt("R6 invalid selected candidate");
  endtask

  task automatic t_conform();
    logic [NPOS*CW-1:0] mp;
    do_reset();
    for (int k = 0; k < NPOS; k++) drop1(32'h900 + k);
    for (int i = 0; i < NPOS; i++) mp[i*CW +: CW] = CW'(NPOS - 1 - i);
    do_op(2'b00, '0, '0, 1'b0, 0, 0, 0, 1'b1, mp);
    check_belt("R7 reverse order");
    for (int i = 0; i < NPOS; i++) mp[i*CW +: CW] = CW'(i);
    mp[0*CW +: CW] = 4'd8;
    mp[3*CW +: CW] = 4'd15;
    mp[5*CW +: CW] = 4'd1;
    mp[6*CW +: CW] = 4'd1;
    do_op(2'b00, '0, '0, 1'b0, 0, 0, 0, 1'b1, mp);
    check_belt("R7/R8/R11 duplicates and out of range");
  endtask

  task automatic t_conform_prio();
    logic [NPOS*CW-1:0] mp;
    for (int i = 0; i < NPOS; i++) mp[i*CW +: CW] = CW'((i + 2) % NPOS);
    do_op(2'b11, 32'hEEEE, 32'hFFFF, 1'b1, 1, 2, 4, 1'b1, mp);
    check_belt("R9 reorder wins over drops and select");
  endtask

  task automatic t_idle();
    repeat (5) @(negedge clk);
    check_belt("R10 idle cycles keep belt");
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    t_reset();
    t_single_drop();
    t_multi_drop();
    t_pick();
    t_pick_invalid();
    t_conform();
    t_conform_prio();
    t_idle();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired: run not finished, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule